// File: doc/BRIEF.md
# Rounded Reciprocal Divider

This block divides one signed fixed-point value by another and returns the quotient rounded to the nearest integer. It serves a lattice-reduction engine, which needs the integer coefficient that subtracts a multiple of one basis column from another. Both operands have the same format, 13 integer and 13 fractional bits in two's complement, so their binary points cancel and the result is a plain 13-bit signed integer. For a complex operand pair the engine uses two copies, one for the real part and one for the imaginary part.

The divider works on magnitudes. It shifts the divisor magnitude left until the leading one reaches the top bit, then reads a starting reciprocal from a 32-entry table indexed by the five bits that follow the leading one. Two Newton-Raphson steps of the form x·(2 − d·x) refine that value. The block multiplies the refined reciprocal by the dividend magnitude and rounds the product. A last stage checks the rounded value against the exact remainder and corrects it by one where needed. It then saturates the result and applies the sign.

The input and the output each use a valid/ready handshake. An operand pair is taken on a clock edge where `in_valid` and `in_ready` are both high. A result leaves on an edge where `out_valid` and `out_ready` are both high. When a result waits with `out_ready` low, the whole pipeline holds: the output stays unchanged, and `in_ready` is low until the result is taken. When nothing is waiting, `in_ready` is high, so a pipeline with gaps takes new work even while `out_ready` is low. Results leave in the order their operands were taken.

Top module: `nr_round_div`

## Requirements
- R1: For a nonzero divisor, `out_quo` equals a/b rounded to the nearest integer, for any operands whose rounded quotient lies within ±4095.
- R2: A quotient lying exactly halfway between two integers is rounded away from zero. For example, 5/2 gives 3 and −5/2 gives −3.
- R3: Negating either operand negates the result, and negating both leaves it unchanged, for all four sign combinations.
- R4: When the rounded magnitude would exceed 4095, the output saturates to +4095 or −4095. The code −4096 is never produced.
- R5: A divisor of zero produces `out_div0` = 1 and `out_quo` = 0. Any other divisor produces `out_div0` = 0.
- R6: With `out_ready` held high, a result is valid 5 cycles after its operands are taken, and back-to-back inputs give one result per cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_quo` and `out_div0` hold their values, and `in_ready` is low.
- R8: Every accepted operand pair produces exactly one result, in the order of acceptance.
- R9: While `rst_n` is low, `out_valid` and `in_ready` are low. In the first cycle after reset, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block takes the operand pair on this edge |
| in_num | input | DW (26) | Dividend, two's complement, 13.13 fixed point |
| in_den | input | DW (26) | Divisor, two's complement, 13.13 fixed point |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Downstream takes the result on this edge |
| out_quo | output | QW (13) | Rounded quotient, two's complement integer |
| out_div0 | output | 1 | Divisor was zero; quotient forced to 0 |

## Verification
The assertions run on every cycle and cover properties that hold however the operands were chosen. They check that a stalled result holds steady, that a zero-divisor result always carries a zero quotient, that the most negative code never appears, that the fixed latency holds whenever the path runs without a stall, and that the output is idle when reset is released. Only the bench's scenarios can show arithmetic correctness. That includes exact rounding at halfway points, symmetry across sign combinations, saturation at the range limit, and the ordering of results under random back-pressure. These depend on operand values that the bench chooses and models, both in directed corner cases and in thousands of random pairs.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;

  // Reciprocal of the midpoint of table bin idx, mantissa range [1,2),
  // returned with fw fractional bits, rounded to nearest.
  function automatic logic [63:0] recip_seed(input int idx, input int idxw, input int fw);
    logic [63:0] den;
    logic [63:0] num;
    den = (64'd1 << (idxw + 1)) + 64'(2 * idx + 1);
    num = (64'd1 << (idxw + 1)) << fw;
    return (num + (den >> 1)) / den;
  endfunction

endpackage

// File: rtl/nr_seed.sv
// Leading-one normaliser and reciprocal seed table.
module nr_seed #(
  parameter int MW   = 26,
  parameter int LZW  = 5,
  parameter int IDXW = 5,
  parameter int FW   = 30,
  parameter int RW   = 31
) (
  input  logic [MW-1:0]  mag,
  output logic [LZW-1:0] lz,
  output logic [MW-1:0]  norm,
  output logic [RW-1:0]  seed
);
  localparam int ENTRIES = 2 ** IDXW;

  always_comb begin
    lz = '0;
    for (int i = 0; i < MW; i++) begin
      if (mag[i]) lz = LZW'(MW - 1 - i);
    end
  end

  assign norm = mag << lz;

  logic [IDXW-1:0] idx;
  assign idx = norm[MW-2 -: IDXW];

  logic [RW-1:0] rom [ENTRIES];
  for (genvar g = 0; g < ENTRIES; g++) begin : g_rom
    assign rom[g] = RW'(nr_div_pkg::recip_seed(g, IDXW, FW));
  end

  assign seed = rom[idx];
endmodule

// File: rtl/nr_iter.sv
// One Newton-Raphson refinement: x_next = x * (2 - m*x).
// m has MW-1 fractional bits, x has FW fractional bits.
module nr_iter #(
  parameter int MW = 26,
  parameter int FW = 30,
  parameter int RW = 31
) (
  input  logic [MW-1:0] m,
  input  logic [RW-1:0] x,
  output logic [RW-1:0] x_next
);
  localparam int PW  = MW + RW;
  localparam int CPW = RW + RW + 1;

  logic [PW-1:0]  mx;
  logic [RW:0]    ef;
  logic [RW:0]    corr;
  logic [CPW-1:0] xc;

  assign mx     = PW'(m) * PW'(x);
  assign ef     = (RW+1)'(mx >> (MW - 1));
  assign corr   = ((RW+1)'(1) << (FW + 1)) - ef;
  assign xc     = CPW'(x) * CPW'(corr);
  assign x_next = RW'(xc >> FW);
endmodule

// File: rtl/nr_quot_est.sv
// Scales dividend by refined reciprocal, rounds half up, caps at 2^(QW-1).
module nr_quot_est #(
  parameter int MW  = 26,
  parameter int RW  = 31,
  parameter int FW  = 30,
  parameter int LZW = 5,
  parameter int QW  = 13
) (
  input  logic [MW-1:0]  a_mag,
  input  logic [RW-1:0]  recip,
  input  logic [LZW-1:0] lz,
  output logic [QW:0]    t_est
);
  localparam int PW  = MW + RW + 1;
  localparam int SHW = $clog2(PW + 1);
  localparam logic [PW-1:0] CAP = PW'(1) << (QW - 1);

  logic [SHW-1:0] sh;
  logic [PW-1:0]  prod;
  logic [PW-1:0]  rnd;
  logic [PW-1:0]  tf;

  assign sh    = SHW'(FW + MW - 1) - SHW'(lz);
  assign prod  = PW'(a_mag) * PW'(recip);
  assign rnd   = prod + ((PW'(1) << sh) >> 1);
  assign tf    = rnd >> sh;
  assign t_est = (tf > CAP) ? (QW+1)'(CAP) : (QW+1)'(tf);
endmodule

// File: rtl/nr_round_fix.sv
// Exact one-step correction against the remainder, then saturation.
module nr_round_fix #(
  parameter int MW = 26,
  parameter int QW = 13
) (
  input  logic [MW-1:0] a_mag,
  input  logic [MW-1:0] b_mag,
  input  logic [QW:0]   t_est,
  output logic [QW-2:0] mag
);
  localparam int CW = QW + MW + 3;
  localparam logic [QW:0] LIM = (QW+1)'((2 ** (QW - 1)) - 1);

  logic [CW-1:0] lhs;
  logic [CW-1:0] rhs;
  logic          up;
  logic [QW:0]   sum;

  assign lhs = (CW'(a_mag) << 1) + CW'(b_mag);
  assign rhs = ((CW'(t_est) << 1) + CW'(2)) * CW'(b_mag);
  assign up  = (lhs >= rhs);
  assign sum = t_est + (QW+1)'(up);
  assign mag = (sum > LIM) ? LIM[QW-2:0] : sum[QW-2:0];
endmodule

// File: rtl/nr_round_div.sv
module nr_round_div #(
  parameter int DW    = 26,
  parameter int QW    = 13,
  parameter int IDXW  = 5,
  parameter int FW    = 30,
  parameter int ITERS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_num,
  input  logic [DW-1:0] in_den,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [QW-1:0] out_quo,
  output logic          out_div0
);
  localparam int MW  = DW;
  localparam int RW  = FW + 1;
  localparam int LZW = $clog2(MW + 1);
  localparam int LAT = ITERS + 3;  // seed, ITERS refinements, estimate, output

  logic adv;
  logic take;
  assign adv      = !out_valid || out_ready;
  assign in_ready = rst_n && adv;
  assign take     = in_valid && in_ready;

  // Operand magnitudes and signs
  logic [MW-1:0] a_in;
  logic [MW-1:0] b_in;
  assign a_in = in_num[DW-1] ? MW'(-in_num) : MW'(in_num);
  assign b_in = in_den[DW-1] ? MW'(-in_den) : MW'(in_den);

  logic [LZW-1:0] lz_in;
  logic [MW-1:0]  norm_in;
  logic [RW-1:0]  seed_in;

  nr_seed #(.MW(MW), .LZW(LZW), .IDXW(IDXW), .FW(FW), .RW(RW)) u_seed (
    .mag  (b_in),
    .lz   (lz_in),
    .norm (norm_in),
    .seed (seed_in)
  );

  // Refinement pipeline, stage 0 holds the seed
  logic           sv   [ITERS+1];
  logic           sneg [ITERS+1];
  logic           sz   [ITERS+1];
  logic [MW-1:0]  sa   [ITERS+1];
  logic [MW-1:0]  sb   [ITERS+1];
  logic [LZW-1:0] slz  [ITERS+1];
  logic [RW-1:0]  sx   [ITERS+1];
  logic [MW-1:0]  sm   [ITERS];
  logic [RW-1:0]  xn   [ITERS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sv[0] <= 1'b0;
    else if (adv) sv[0] <= take;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      sneg[0] <= in_num[DW-1] ^ in_den[DW-1];
      sz[0]   <= (b_in == '0);
      sa[0]   <= a_in;
      sb[0]   <= b_in;
      slz[0]  <= lz_in;
      sx[0]   <= seed_in;
      sm[0]   <= norm_in;
    end
  end

  for (genvar k = 0; k < ITERS; k++) begin : g_iter
    nr_iter #(.MW(MW), .FW(FW), .RW(RW)) u_iter (
      .m      (sm[k]),
      .x      (sx[k]),
      .x_next (xn[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sv[k+1] <= 1'b0;
      else if (adv) sv[k+1] <= sv[k];
    end

    always_ff @(posedge clk) begin
      if (adv) begin
        sneg[k+1] <= sneg[k];
        sz[k+1]   <= sz[k];
        sa[k+1]   <= sa[k];
        sb[k+1]   <= sb[k];
        slz[k+1]  <= slz[k];
        sx[k+1]   <= xn[k];
      end
    end

    if (k + 1 < ITERS) begin : g_mcarry
      always_ff @(posedge clk) begin
        if (adv) sm[k+1] <= sm[k];
      end
    end
  end

  // Quotient estimate stage
  logic [QW:0]   t_comb;
  logic          ev;
  logic          eneg;
  logic          ez;
  logic [MW-1:0] ea;
  logic [MW-1:0] eb;
  logic [QW:0]   et;

  nr_quot_est #(.MW(MW), .RW(RW), .FW(FW), .LZW(LZW), .QW(QW)) u_est (
    .a_mag (sa[ITERS]),
    .recip (sx[ITERS]),
    .lz    (slz[ITERS]),
    .t_est (t_comb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev <= 1'b0;
    else if (adv) ev <= sv[ITERS];
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      eneg <= sneg[ITERS];
      ez   <= sz[ITERS];
      ea   <= sa[ITERS];
      eb   <= sb[ITERS];
      et   <= t_comb;
    end
  end

  // Correction, sign and output register
  logic [QW-2:0] mag_fix;

  nr_round_fix #(.MW(MW), .QW(QW)) u_fix (
    .a_mag (ea),
    .b_mag (eb),
    .t_est (et),
    .mag   (mag_fix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (adv) out_valid <= ev;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      out_div0 <= ez;
      if (ez) out_quo <= '0;
      else if (eneg) out_quo <= -QW'(mag_fix);
      else out_quo <= QW'(mag_fix);
    end
  end
endmodule

// File: rtl/nr_round_div_chk.sv
module nr_round_div_chk #(
  parameter int QW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [QW-1:0] out_quo,
  input logic          out_div0
);
  localparam logic [QW-1:0] MOST_NEG = {1'b1, {(QW-1){1'b0}}};

  // R7: a stalled result does not change
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_quo) && $stable(out_div0));

  // R5: zero divisor result carries zero quotient
  a_r5_div0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_div0 |-> out_quo == '0);

  // R4: symmetric saturation never yields the most negative code
  a_r4_no_most_neg: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_quo != MOST_NEG);

  // R6: five-cycle latency when no stall occurs (default two refinements)
  a_r6_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 5) &&
     $past(out_ready, 1) && $past(out_ready, 2) && $past(out_ready, 3) && $past(out_ready, 4) &&
     $past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) && $past(rst_n, 4))
    |-> out_valid);

  // R9: output idle when reset is released
  a_r9_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

bind nr_round_div nr_round_div_chk #(.QW(QW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_quo   (out_quo),
  .out_div0  (out_div0)
);

// File: tb/nr_round_div_test.sv
`timescale 1ns/1ps
module nr_round_div_test;
  localparam int DW  = 26;
  localparam int QW  = 13;
  localparam longint LIM = 4095;
  localparam longint AMAX = 33554431;
  localparam longint AMIN = -33554432;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_num = '0;
  logic [DW-1:0] in_den = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [QW-1:0] out_quo;
  logic          out_div0;

  always #10 clk = ~clk;

  nr_round_div uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_num(in_num), .in_den(in_den), .out_valid(out_valid), .out_ready(out_ready),
    .out_quo(out_quo), .out_div0(out_div0)
  );

  int checks = 0;
  int errors = 0;
  int accepted = 0;
  int delivered = 0;
  bit fired;
  bit done = 0;
  logic [QW-1:0] exp_q [$];
  bit            exp_z [$];
  string         exp_t [$];

  function automatic void model(input longint a, input longint b,
                                output logic [QW-1:0] q, output bit z, output string tag);
    longint aa, bb, r, m;
    aa = (a < 0) ? -a : a;
    bb = (b < 0) ? -b : b;
    if (b == 0) begin
      q = '0; z = 1'b1; tag = "R5";
      return;
    end
    r = (2 * aa + bb) / (2 * bb);
    m = (r > LIM) ? LIM : r;
    if (r > LIM) tag = "R4";
    else if (((2 * aa) % (2 * bb)) == bb) tag = "R2";
    else tag = "R1";
    q = ((a < 0) != (b < 0)) ? QW'(-m) : QW'(m);
    z = 1'b0;
  endfunction

  task automatic check(input string req, input bit ok, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic step(input bit v, input longint a, input longint b, input bit rdy, input string ftag);
    logic [QW-1:0] eq;
    bit ez;
    string et;
    logic [QW-1:0] pq;
    bit pz;
    string pt;
    @(negedge clk);
    in_valid = v; in_num = DW'(a); in_den = DW'(b); out_ready = rdy;
    #1;
    fired = 1'b0;
    if (out_valid && out_ready) begin
      fired = 1'b1;
      delivered++;
      if (exp_q.size() == 0) begin
        check("R8", 1'b0, 1, 0);
      end else begin
        eq = exp_q.pop_front(); ez = exp_z.pop_front(); et = exp_t.pop_front();
        checks++;
        if (out_quo !== eq || out_div0 !== ez) begin
          errors++;
          $display("FAIL %s: quotient %0d div0 %0b, expected %0d div0 %0b",
                   et, $signed(out_quo), out_div0, $signed(eq), ez);
        end
      end
    end
    if (in_valid && in_ready) begin
      model(longint'($signed(in_num)), longint'($signed(in_den)), pq, pz, pt);
      if (ftag != "") pt = ftag;
      exp_q.push_back(pq); exp_z.push_back(pz); exp_t.push_back(pt);
      accepted++;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) step(0, 0, 0, 1, "");
    step(0, 0, 0, 1, "");
  endtask

  task automatic gen(output longint a, output longint b);
    int mode;
    longint bm, q, f;
    mode = int'($urandom % 8);
    if (mode == 0) begin
      a = longint'($signed(DW'($urandom)));
      b = longint'($signed(DW'($urandom))) >>> ($urandom % 26);
      return;
    end
    if (mode == 1 && ($urandom % 4) == 0) begin
      a = longint'($signed(DW'($urandom))); b = 0;
      return;
    end
    bm = longint'($urandom % (32'd1 << ($urandom % 14))) + 1;
    b  = ($urandom % 2) ? -bm : bm;
    q  = longint'($urandom % 8401) - 4200;
    case ($urandom % 3)
      0: f = 0;
      1: f = (bm % 2 == 0) ? bm / 2 : longint'($urandom) % bm;
      default: f = longint'($urandom) % bm;
    endcase
    a = q * b + (($urandom % 2) ? f : -f);
    if (a > AMAX) a = AMAX;
    if (a < AMIN) a = AMIN;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint a, b;
    int first, last, cnt;
    logic [QW-1:0] held;
    void'($urandom(32'd20240611));

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", out_valid == 1'b0, out_valid, 0);
    check("R9", in_ready == 1'b0, in_ready, 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R9", in_ready == 1'b1, in_ready, 1);

    // R2: halfway points, all signs
    step(1, 5, 2, 1, "R2");
    step(1, -5, 2, 1, "R2");
    step(1, 1, 2, 1, "R2");
    step(1, -1, 2, 1, "R2");
    step(1, 3, -2, 1, "R2");
    step(1, -3, -2, 1, "R2");
    step(1, 61440, 8192, 1, "R2");   // 7.5
    step(1, 8187 * 4096, 8192, 1, "R2"); // 4093.5
    // R1: plain cases and extremes
    step(1, 0, 5, 1, "R1");
    step(1, 7, 3, 1, "R1");
    step(1, 33554431, -33554432, 1, "R1");
    step(1, 100, 33554431, 1, "R1");
    step(1, 4094 * 3 + 1, 3, 1, "R1");
    // R3: sign symmetry
    step(1, 123457, 991, 1, "R3");
    step(1, -123457, 991, 1, "R3");
    step(1, 123457, -991, 1, "R3");
    step(1, -123457, -991, 1, "R3");
    // R4: saturation edges
    step(1, 8191 * 1000, 2000, 1, "R4");  // 4095.5 -> 4096 -> 4095
    step(1, -8191 * 1000, 2000, 1, "R4");
    step(1, -33554432, -1, 1, "R4");
    step(1, 33554431, 1, 1, "R4");
    step(1, 4095 * 77 + 38, 77, 1, "R4"); // 4095.49 -> 4095
    // R5: zero divisor
    step(1, 12345, 0, 1, "R5");
    step(1, -33554432, 0, 1, "R5");
    drain();

    // R6: latency
    step(1, 100, 7, 1, "R6");
    first = -1;
    for (int k = 1; k <= 8; k++) begin
      step(0, 0, 0, 1, "");
      if (fired && first < 0) first = k;
    end
    check("R6", first == 5, first, 5);

    // R6: throughput
    first = -1; last = -1; cnt = 0;
    for (int k = 0; k < 20; k++) begin
      if (k < 8) step(1, 1000 * (k + 1) + 13, 9 + k, 1, "R6");
      else step(0, 0, 0, 1, "");
      if (fired) begin
        cnt++;
        if (first < 0) first = k;
        last = k;
      end
    end
    check("R6", cnt == 8, cnt, 8);
    check("R6", (last - first) == 7, last - first, 7);

    // R7: back-pressure
    step(1, 50, 3, 0, "R7");
    for (int k = 1; k <= 5; k++) step(0, 0, 0, 0, "");
    check("R7", out_valid == 1'b1, out_valid, 1);
    held = out_quo;
    check("R7", held == 13'd17, held, 17);
    for (int k = 0; k < 3; k++) begin
      step(1, 999, 1, 0, "");
      check("R7", in_ready == 1'b0, in_ready, 0);
      check("R7", out_quo == held, out_quo, held);
    end
    drain();

    // Random traffic with random back-pressure
    for (int n = 0; n < 3000; n++) begin
      gen(a, b);
      step(($urandom % 5) != 0, a, b, ($urandom % 10) < 7, "");
      while (in_valid && !in_ready) step(1, a, b, ($urandom % 10) < 7, "") ;
    end
    drain();

    // R8: one result per accepted pair
    check("R8", exp_q.size() == 0, exp_q.size(), 0);
    check("R8", accepted == delivered, delivered, accepted);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule